// File: doc/BRIEF.md
# Two-Phase Interframe Gap Deferral

This block decides when a half-duplex transmitter may begin a frame after the medium falls quiet. It counts bit-time strobes after the medium goes idle or after the block's own transmission ends. The interframe gap is split into two windows. In the early window the count is still sensitive to the medium: any carrier sends it back to zero, and counting starts again once carrier is gone. In the late window the transmitter has committed, so carrier is disregarded and access follows when the window runs out.

The transmit path raises a request and waits for the permit. It then reports the first cycle of its frame and, later, the cycle its frame finishes. In full-duplex operation the medium is never sensed. Only the gap after the block's own frame is timed. After reset the block acts as though a whole gap has already passed.

Top module: `ifg_defer`

## Requirements
- R1: After reset, with no carrier, a pending request gets a permit at once, with no bit-time strobes needed.
- R2: The count advances only on cycles where `bit_tick` is 1. The permit appears only once 96 strobes (64 early plus 32 late) have been counted since the last restart.
- R3: In half duplex, carrier on any cycle while fewer than 64 strobes have been counted resets the count to zero. This includes the cycle of the 64th strobe. The count stays at zero while carrier lasts and resumes once carrier is gone.
- R4: In half duplex, carrier that appears once 64 or more strobes have been counted does not disturb the count. The permit is granted at 96 strobes even if carrier is still present.
- R5: In half duplex, once the gap is complete, a new rise of carrier restarts the full gap. Carrier that was already present at the end of the late window does not restart it.
- R6: In full duplex (`full_duplex` = 1), carrier has no effect at all. Only the end of the block's own transmission restarts the 96-strobe gap.
- R7: `tx_permit` is 1 exactly when `tx_req` is 1, the gap is complete and no own frame is in progress. From the cycle after `tx_sof` until `tx_end`, the permit is 0.
- R8: The cycle after `tx_end`, the count starts again from zero, so a new permit needs another 96 strobes.
- R9: The count saturates once the gap is complete. Extra strobes keep the permit available.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| carrier | input | 1 | Carrier sense from the medium |
| full_duplex | input | 1 | 1 selects full duplex, 0 selects half duplex |
| tx_req | input | 1 | Transmitter has a frame pending |
| tx_sof | input | 1 | Transmitter starts its frame this cycle |
| tx_end | input | 1 | Transmitter finishes its frame this cycle |
| tx_permit | output | 1 | Transmission may begin |

## Verification
The gap is driven in several ways:
- Continuous strobes and sparse, alternating strobes. The two show counting by strobes apart from counting by clocks.
- Carrier at the last early-window strobe and at the first late-window strobe. The two mark the exact boundary where restarts stop.
- Carrier that begins in the late window and is still present at completion, set against carrier that rises after completion. This separates the commit rule from ordinary deferral.
- A full-duplex pass with carrier toggling throughout. It confirms that only the end of the block's own frame restarts the gap.

// File: rtl/ifg_defer.sv
module ifg_defer #(
  parameter int P1_BITS = 64,
  parameter int P2_BITS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic carrier,
  input  logic full_duplex,
  input  logic tx_req,
  input  logic tx_sof,
  input  logic tx_end,
  output logic tx_permit
);
  localparam int TOTAL = P1_BITS + P2_BITS;
  localparam int CW = $clog2(TOTAL + 1);
  localparam logic [CW-1:0] P1_C = CW'(P1_BITS);
  localparam logic [CW-1:0] TOT_C = CW'(TOTAL);

  logic [CW-1:0] gap_cnt;
  logic tx_active, car_q;

  wire gap_done = (gap_cnt == TOT_C);
  wire in_p1 = (gap_cnt < P1_C);
  wire sense_hit = !full_duplex && carrier && (in_p1 || (gap_done && !car_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt <= TOT_C;
      tx_active <= 1'b0;
      car_q <= 1'b0;
    end else begin
      car_q <= carrier;
      if (tx_sof) tx_active <= 1'b1;
      else if (tx_end) tx_active <= 1'b0;
      if (tx_sof || tx_active || sense_hit) gap_cnt <= '0;
      else if (bit_tick && !gap_done) gap_cnt <= gap_cnt + 1'b1;
    end
  end

  assign tx_permit = tx_req && gap_done && !tx_active;

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    gap_cnt <= TOT_C);
  a_r7_sof_drops: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sof |=> !tx_permit);
  a_r8_end_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |=> gap_cnt == '0);
  a_r3_early_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_duplex && carrier && in_p1) |=> gap_cnt == '0);
  a_r4_late_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_duplex && carrier && !in_p1 && !gap_done && !tx_active && !tx_sof)
      |=> gap_cnt >= $past(gap_cnt) && gap_cnt != '0);
  a_r6_fd_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (full_duplex && bit_tick && !gap_done && !tx_active && !tx_sof)
      |=> gap_cnt == $past(gap_cnt) + 1'b1);
endmodule

// File: tb/tb_ifg_defer.sv
`timescale 1ns/1ps
module tb_ifg_defer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_tick = 0, carrier = 0, full_duplex = 0, tx_req = 0, tx_sof = 0, tx_end = 0;
  logic tx_permit;
  int vectors = 0, errors = 0;
  int gap = 96;
  bit busy = 0, cprev = 0;

  ifg_defer dut (.*);

  always #2.5 clk = ~clk;

  // one cycle: drive at negedge, compare before edge, advance model at edge
  task automatic cyc(input bit tk, input bit car, input bit req,
                     input bit sof, input bit en, input string tag);
    bit exp;
    @(negedge clk);
    bit_tick = tk; carrier = car; tx_req = req; tx_sof = sof; tx_end = en;
    #1;
    exp = req && gap == 96 && !busy;
    vectors++;
    if (tx_permit !== exp) begin
      errors++;
      $display("FAIL %s: tx_permit=%0b expected=%0b (gap model %0d)", tag, tx_permit, exp, gap);
    end
    @(posedge clk);
    if (sof || busy) gap = 0;
    else if (!full_duplex && car && (gap < 64 || (gap == 96 && !cprev))) gap = 0;
    else if (tk && gap < 96) gap++;
    if (sof) busy = 1; else if (en) busy = 0;
    cprev = car;
  endtask

  task automatic own_frame(input string tag);
    cyc(1, 0, 1, 1, 0, tag);
    for (int i = 0; i < 4; i++) cyc(1, 0, 1, 0, 0, tag);
    cyc(1, 0, 1, 0, 1, tag);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: permit immediately after reset
    cyc(0, 0, 1, 0, 0, "R1");
    cyc(0, 0, 1, 0, 0, "R1");
    // R7 / R8: own frame then full gap
    own_frame("R7");
    for (int i = 0; i < 100; i++) cyc(1, 0, 1, 0, 0, "R8");
    // R2: sparse strobes
    own_frame("R2");
    for (int i = 0; i < 220; i++) cyc(i % 2 == 0, 0, 1, 0, 0, "R2");
    // R3: carrier mid early window, then at last early strobe
    own_frame("R3");
    for (int i = 0; i < 30; i++) cyc(1, 0, 1, 0, 0, "R3");
    for (int i = 0; i < 3; i++) cyc(1, 1, 1, 0, 0, "R3");
    for (int i = 0; i < 63; i++) cyc(1, 0, 1, 0, 0, "R3");
    cyc(1, 1, 1, 0, 0, "R3");
    for (int i = 0; i < 100; i++) cyc(1, 0, 1, 0, 0, "R3");
    // R4: carrier from first late strobe, held through completion
    own_frame("R4");
    for (int i = 0; i < 64; i++) cyc(1, 0, 1, 0, 0, "R4");
    for (int i = 0; i < 40; i++) cyc(1, 1, 1, 0, 0, "R4");
    // R5: carrier drops, then a new rise after completion restarts
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, "R5");
    cyc(1, 1, 1, 0, 0, "R5");
    for (int i = 0; i < 5; i++) cyc(1, 1, 1, 0, 0, "R5");
    for (int i = 0; i < 100; i++) cyc(1, 0, 1, 0, 0, "R5");
    // R6: full duplex ignores carrier
    @(negedge clk); full_duplex = 1'b1;
    own_frame("R6");
    for (int i = 0; i < 100; i++) cyc(1, i % 3 == 0, 1, 0, 0, "R6");
    cyc(1, 1, 1, 0, 0, "R6");
    cyc(1, 0, 1, 0, 0, "R6");
    @(negedge clk); full_duplex = 1'b0;
    // R9: saturation with many extra strobes
    for (int i = 0; i < 300; i++) cyc(1, 0, i % 5 != 0, 0, 0, "R9");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule